// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Controller

This block is a bus master that converts single read or write requests from an internal request/acknowledge port into strobe sequences for an external asynchronous device with static-memory style access, such as SRAM, NOR flash or peripheral chips that use the same style. On the device side it drives an address bus, a shared tri-state data bus, an active-low chip select, separate active-low read and write strobes and active-low byte-lane enables. It samples an active-low wait input that the device uses to stretch an access.

Every access runs the same fixed sequence. First comes an address-only cycle, then a chip-select lead-in whose length is programmable, then the strobe, then a programmable hold. A configuration register holds the three timing fields. It is captured when a request is accepted, so a slow part can be served by writing longer counts. The device's wait line is synchronized, and it only extends the strobe after the programmed minimum has run out. The requester holds its request until the one-cycle acknowledge, which carries the read data.

Top module: `asram_ctrl`

## Requirements
- R1: While and after reset, with no request, mem_cs_n, mem_oe_n, mem_we_n and every bit of mem_be_n are high, req_ack is low and the controller does not drive mem_dq.
- R2: An accepted request drives mem_addr for exactly one cycle with mem_cs_n high. mem_cs_n then goes low for setup+1 cycles with both strobes high before the strobe starts. setup is taken from cfg_wdata[9:6] and ranges over 0..15.
- R3: With mem_wait_n high, the strobe (mem_oe_n for reads, mem_we_n for writes) stays low for S cycles. S is cfg_wdata[5:0], and a written value of 0 is taken as 1. Only the strobe that matches the access type ever goes low.
- R4: If mem_wait_n is low when the strobe starts and the bench releases it in the L-th strobe cycle, the strobe lasts max(S, L+2) cycles. This is because the line passes through a two-flop synchronizer.
- R5: A wait released before the programmed minimum runs out does not shorten the strobe: it still lasts S cycles.
- R6: After the strobe ends, mem_cs_n stays low with both strobes high for H cycles. H is cfg_wdata[13:10] and ranges over 0..15. mem_addr stays unchanged from the address cycle through the end of the hold.
- R7: req_ack is high for exactly one cycle, the cycle right after the last hold cycle (or after the last strobe cycle when H is 0).
- R8: On a read, req_rdata during the acknowledge cycle equals the value the device drove on mem_dq in the last strobe cycle.
- R9: On a write, mem_dq carries req_wdata from the address cycle through the last hold cycle. On a read, the controller never drives mem_dq while mem_oe_n is low.
- R10: While mem_cs_n is low, mem_be_n equals the inverse of req_be captured at acceptance (bit i enables data byte i). Otherwise mem_be_n is all ones.
- R11: In the acknowledge cycle mem_cs_n, mem_oe_n and mem_we_n are all high, so two accesses are always separated by at least one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the timing register |
| cfg_wdata | input | CFG_W (14) | Timing fields: strobe [5:0], setup [9:6], hold [13:10] |
| req | input | 1 | Request, held until req_ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | BE_W | Byte-lane enables, active high |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | DATA_W | Read data, valid with req_ack |
| mem_addr | output | ADDR_W | Device address bus |
| mem_dq | inout | DATA_W | Device data bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_be_n | output | BE_W | Byte-lane enables, active low |
| mem_wait_n | input | 1 | Device wait, active low |

## Verification
The assertions check the pin ordering on every cycle. They confirm that the address is steady when chip select falls, that chip select leads the strobe, and that the address holds while the device is selected. They also check that the two strobes never overlap, that the data-bus drive matches the access direction, and that the acknowledge is a single idle-cycle pulse. The exact phase lengths need the bench's scenarios: setup, strobe and hold counts for each configuration, the wait-stretch latency through the synchronizer, and the minimum that an early wait release cannot cut short. The read data captured at the end of the strobe and the byte-lane pattern for each access are also checked by the bench.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_CSON = 3'd2,
    PH_STRB = 3'd3,
    PH_HOLD = 3'd4
  } phase_t;

  function automatic bit phase_selected(input phase_t ph);
    return (ph == PH_CSON) || (ph == PH_STRB) || (ph == PH_HOLD);
  endfunction

  function automatic bit phase_busy(input phase_t ph);
    return (ph != PH_IDLE);
  endfunction

endpackage

// File: rtl/asram_cfg_reg.sv
module asram_cfg_reg #(
  parameter int STRB_W  = 6,
  parameter int SETUP_W = 4,
  parameter int HOLD_W  = 4,
  parameter int STRB_RST  = 4,
  parameter int SETUP_RST = 1,
  parameter int HOLD_RST  = 1,
  localparam int CFG_W = STRB_W + SETUP_W + HOLD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [CFG_W-1:0]   wr_data,
  output logic [STRB_W-1:0]  strb_cyc,
  output logic [SETUP_W-1:0] setup_cyc,
  output logic [HOLD_W-1:0]  hold_cyc
);

  localparam int SETUP_LSB = STRB_W;
  localparam int HOLD_LSB  = STRB_W + SETUP_W;

  logic [STRB_W-1:0] strb_field;

  assign strb_field = wr_data[STRB_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_cyc  <= STRB_W'(STRB_RST);
      setup_cyc <= SETUP_W'(SETUP_RST);
      hold_cyc  <= HOLD_W'(HOLD_RST);
    end else if (wr_en) begin
      // a zero strobe count would make the strobe vanish: clamp to one
      strb_cyc  <= (strb_field == '0) ? STRB_W'(1) : strb_field;
      setup_cyc <= wr_data[SETUP_LSB +: SETUP_W];
      hold_cyc  <= wr_data[HOLD_LSB +: HOLD_W];
    end
  end

endmodule

// File: rtl/asram_sync.sv
module asram_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 32,
  parameter int STRB_W  = 6,
  parameter int SETUP_W = 4,
  parameter int HOLD_W  = 4,
  localparam int BE_W   = DATA_W / 8,
  localparam int CNT_W  = (STRB_W >= SETUP_W) ?
                          ((STRB_W >= HOLD_W) ? STRB_W : HOLD_W) :
                          ((SETUP_W >= HOLD_W) ? SETUP_W : HOLD_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic               req_we,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [BE_W-1:0]    req_be,
  input  logic [STRB_W-1:0]  cfg_strb,
  input  logic [SETUP_W-1:0] cfg_setup,
  input  logic [HOLD_W-1:0]  cfg_hold,
  input  logic               dev_ready,
  input  logic [DATA_W-1:0]  dq_in,
  output logic               ack,
  output logic [DATA_W-1:0]  rdata,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  dq_out,
  output logic               dq_oe,
  output logic               cs_n,
  output logic               oe_n,
  output logic               we_n,
  output logic [BE_W-1:0]    be_n
);

  phase_t ph_q, ph_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [STRB_W-1:0]  strb_q;
  logic [SETUP_W-1:0] setup_q;
  logic [HOLD_W-1:0]  hold_q;
  logic [BE_W-1:0]    be_q;
  logic               wr_q;
  logic               accept;
  logic               ack_d;
  logic               capture;
  logic               wr_next;

  // next phase and counter
  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    accept  = 1'b0;
    ack_d   = 1'b0;
    capture = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        // ack high means the previous access just ended: stay idle once
        if (req && !ack) begin
          accept = 1'b1;
          ph_d   = PH_ADDR;
        end
      end
      PH_ADDR: begin
        ph_d  = PH_CSON;
        cnt_d = CNT_W'(setup_q);
      end
      PH_CSON: begin
        if (cnt_q == '0) begin
          ph_d  = PH_STRB;
          cnt_d = CNT_W'(strb_q) - CNT_W'(1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_STRB: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (dev_ready) begin
          capture = !wr_q;
          if (hold_q == '0) begin
            ph_d  = PH_IDLE;
            ack_d = 1'b1;
          end else begin
            ph_d  = PH_HOLD;
            cnt_d = CNT_W'(hold_q) - CNT_W'(1);
          end
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          ph_d  = PH_IDLE;
          ack_d = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  assign wr_next = accept ? req_we : wr_q;

  // phase state and per-access snapshot
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      strb_q  <= STRB_W'(1);
      setup_q <= '0;
      hold_q  <= '0;
      be_q    <= '0;
      wr_q    <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      if (accept) begin
        strb_q  <= cfg_strb;
        setup_q <= cfg_setup;
        hold_q  <= cfg_hold;
        be_q    <= req_be;
        wr_q    <= req_we;
      end
    end
  end

  // registered pin outputs, decoded from the next phase
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
      cs_n     <= 1'b1;
      oe_n     <= 1'b1;
      we_n     <= 1'b1;
      be_n     <= '1;
      ack      <= 1'b0;
      rdata    <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        dq_out   <= req_wdata;
      end
      dq_oe <= phase_busy(ph_d) && wr_next;
      cs_n  <= !phase_selected(ph_d);
      oe_n  <= !((ph_d == PH_STRB) && !wr_next);
      we_n  <= !((ph_d == PH_STRB) && wr_next);
      be_n  <= phase_selected(ph_d) ? ~be_q : '1;
      ack   <= ack_d;
      if (capture) rdata <= dq_in;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 32,
  parameter int STRB_W  = 6,
  parameter int SETUP_W = 4,
  parameter int HOLD_W  = 4,
  parameter int SYNC_STAGES = 2,
  localparam int BE_W  = DATA_W / 8,
  localparam int CFG_W = STRB_W + SETUP_W + HOLD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              req_ack,
  output logic [DATA_W-1:0] req_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [BE_W-1:0]   mem_be_n,
  input  logic              mem_wait_n
);

  logic [STRB_W-1:0]  strb_cyc;
  logic [SETUP_W-1:0] setup_cyc;
  logic [HOLD_W-1:0]  hold_cyc;
  logic               dev_ready;
  logic [DATA_W-1:0]  dq_out;
  logic               dq_oe;

  asram_cfg_reg #(
    .STRB_W (STRB_W),
    .SETUP_W(SETUP_W),
    .HOLD_W (HOLD_W)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_data  (cfg_wdata),
    .strb_cyc (strb_cyc),
    .setup_cyc(setup_cyc),
    .hold_cyc (hold_cyc)
  );

  asram_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_wait_sync (
    .clk(clk),
    .rst(rst),
    .d  (mem_wait_n),
    .q  (dev_ready)
  );

  asram_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .STRB_W (STRB_W),
    .SETUP_W(SETUP_W),
    .HOLD_W (HOLD_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .req_we   (req_we),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_be   (req_be),
    .cfg_strb (strb_cyc),
    .cfg_setup(setup_cyc),
    .cfg_hold (hold_cyc),
    .dev_ready(dev_ready),
    .dq_in    (mem_dq),
    .ack      (req_ack),
    .rdata    (req_rdata),
    .mem_addr (mem_addr),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .cs_n     (mem_cs_n),
    .oe_n     (mem_oe_n),
    .we_n     (mem_we_n),
    .be_n     (mem_be_n)
  );

  assign mem_dq = dq_oe ? dq_out : {DATA_W{1'bz}};

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              ack,
  input logic              dq_oe
);

  logic strobe_idle;
  assign strobe_idle = mem_oe_n && mem_we_n;

  // R2: address already settled and no strobe when chip select falls
  a_r2_addr_before_cs: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_cs_n) |-> ($stable(mem_addr) && strobe_idle));

  // R2: chip select was already low in the cycle before a strobe begins
  a_r2_cs_before_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_idle) |-> $past(!mem_cs_n));

  // R6: address steady while the device stays selected
  a_r6_addr_steady: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  // R3: only one strobe at a time
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  // R9: bus released during reads, driven during writes
  a_r9_read_released: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !dq_oe);

  a_r9_write_driven: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> dq_oe);

  // R7: acknowledge is a single-cycle pulse
  a_r7_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R11: the acknowledge cycle is idle on the device side
  a_r11_idle_on_ack: assert property (@(posedge clk) disable iff (rst)
    ack |-> (mem_cs_n && strobe_idle));

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mem_addr(mem_addr),
  .mem_cs_n(mem_cs_n),
  .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n),
  .ack     (req_ack),
  .dq_oe   (dq_oe)
);

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int CW = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic          req = 1'b0;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [BW-1:0] req_be = '0;
  logic          req_ack;
  logic [DW-1:0] req_rdata;
  logic [AW-1:0] mem_addr;
  wire  [DW-1:0] mem_dq;
  logic          mem_cs_n, mem_oe_n, mem_we_n;
  logic [BW-1:0] mem_be_n;
  logic          mem_wait_n = 1'b1;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] dev_word(input logic [AW-1:0] a);
    return {a[15:0] ^ 16'hA5C3, a[15:0] + 16'h1234};
  endfunction

  function automatic int exp_strobe(input int s, input int l);
    int base;
    base = (s == 0) ? 1 : s;
    if (l < 1) return base;
    return (l + 2 > base) ? l + 2 : base;
  endfunction

  logic [DW-1:0] dev_rd;
  assign dev_rd = dev_word(mem_addr);
  assign mem_dq = (!mem_cs_n && !mem_oe_n) ? dev_rd : {DW{1'bz}};

  asram_ctrl uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .req_ack(req_ack), .req_rdata(req_rdata),
    .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
    .mem_wait_n(mem_wait_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int s, input int su, input int h);
    @(negedge clk);
    cfg_wdata = {4'(h), 4'(su), 6'(s)};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one access, phase lengths measured at negedges; wl < 1 means no wait
  task automatic access(input bit we, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input logic [BW-1:0] be,
                        input int s, input int su, input int h, input int wl);
    int n_a = 0, n_c = 0, n_s = 0, n_h = 0, guard = 0;
    bit seen_s = 1'b0, bus_ok = 1'b1, be_ok = 1'b1, adr_ok = 1'b1, pin_ok = 1'b1;
    @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = wd; req_be = be;
    if (wl >= 1) mem_wait_n = 1'b0;
    forever begin
      @(negedge clk);
      guard++;
      if (req_ack || guard > 400) break;
      if (mem_addr != a) adr_ok = 1'b0;
      if (we && mem_dq != wd) bus_ok = 1'b0;
      if (mem_cs_n) begin
        n_a++;
        if (mem_be_n != '1) be_ok = 1'b0;
      end else begin
        if (mem_be_n != ~be) be_ok = 1'b0;
        if (!mem_oe_n || !mem_we_n) begin
          seen_s = 1'b1;
          n_s++;
          if (we ? (mem_we_n || !mem_oe_n) : (mem_oe_n || !mem_we_n)) pin_ok = 1'b0;
          if (wl >= 1 && n_s == wl) mem_wait_n = 1'b1;
        end else if (!seen_s) n_c++;
        else n_h++;
      end
    end
    chk(guard <= 400, "R7 ack arrives", guard, 400);
    chk(mem_cs_n && mem_oe_n && mem_we_n, "R11 idle on ack",
        {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
    req = 1'b0;
    mem_wait_n = 1'b1;
    chk(n_a == 1, "R2 address-only cycles", n_a, 1);
    chk(n_c == su + 1, "R2 cs lead-in cycles", n_c, su + 1);
    chk(n_s == exp_strobe(s, wl), (wl >= 1) ? "R4/R5 stretched strobe" : "R3 strobe length",
        n_s, exp_strobe(s, wl));
    chk(pin_ok, "R3 strobe matches access type", pin_ok, 1);
    chk(n_h == h, "R6 hold cycles", n_h, h);
    chk(adr_ok, "R6 address stable", adr_ok, 1);
    chk(be_ok, "R10 byte enables", be_ok, 1);
    if (we) chk(bus_ok, "R9 write data on bus", bus_ok, 1);
    else    chk(req_rdata == dev_word(a), "R8 read data", req_rdata, dev_word(a));
    @(negedge clk);
    chk(!req_ack, "R7 ack single cycle", req_ack, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n && mem_be_n == '1 && !req_ack,
        "R1 outputs idle in reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_be_n}, 7'h7F);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n && !req_ack && mem_be_n == '1,
        "R1 idle after reset", {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);

    // directed corners
    set_cfg(1, 0, 0);
    access(1'b0, 20'h00010, '0, 4'hF, 1, 0, 0, 0);
    set_cfg(0, 2, 1);
    access(1'b1, 20'h12345, 32'hDEADBEEF, 4'h5, 0, 2, 1, 0);
    set_cfg(63, 15, 15);
    access(1'b1, 20'hFFFFF, 32'h0BADF00D, 4'hA, 63, 15, 15, 0);
    access(1'b0, 20'hABCDE, '0, 4'h3, 63, 15, 15, 0);
    set_cfg(3, 1, 2);
    access(1'b0, 20'h00777, '0, 4'h1, 3, 1, 2, 12);
    access(1'b1, 20'h00778, 32'h11223344, 4'hC, 3, 1, 2, 30);
    set_cfg(20, 1, 1);
    access(1'b0, 20'h04242, '0, 4'hF, 20, 1, 1, 2);
    access(1'b0, 20'h04243, '0, 4'hF, 20, 1, 1, 18);
    access(1'b1, 20'h04244, 32'hCAFE0001, 4'h8, 20, 1, 1, 19);

    // random mix
    for (int i = 0; i < 60; i++) begin
      int s, su, h, wl;
      s  = int'($urandom % 64);
      su = int'($urandom % 16);
      h  = int'($urandom % 16);
      wl = ($urandom % 3 == 0) ? int'(1 + $urandom % 70) : 0;
      set_cfg(s, su, h);
      access(1'($urandom), AW'($urandom), $urandom, BW'($urandom), s, su, h, wl);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule